// File: doc/BRIEF.md
# Warp Divergence and Reconvergence Stack

This block tracks which of the 32 lanes of one warp are active while the warp runs through branches whose condition differs from lane to lane. When a branch arrives with a per-lane predicate that splits the active lanes, the block first runs the taken path with only the agreeing lanes enabled. It then runs the other path with the remaining lanes. When the program reaches the reconvergence address, it restores the mask the warp had before the branch. Lanes that are masked off do no work. Pending paths and rejoin points are held on a small hardware stack of (mask, PC, reconvergence PC) records.

A start strobe loads a warp with its entry PC and its live lane count. Lanes at or above that count are dormant for the whole run. The fetch side reports each branch on the branch port. It also raises the reach strobe with the PC it has arrived at, so the block can pop a pending path once that PC matches the current reconvergence PC. A branch whose fall-through address equals its reconvergence address, for example a loop exit test, needs no separate second pass. A loop exit test that repeats against the same reconvergence point only narrows the mask, so lanes leave a data-dependent loop one iteration at a time. The block drives the current mask, its population count and the PC the warp should fetch next.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, activeMask is 0, pcOut is 0, activeCount is 0 and overflow is 0. A start strobe sets lane i active exactly when i < liveLanes, loads pcOut from startPc, empties the stack and clears overflow, all visible one cycle later.
- R2: A lane at or above the live count never becomes active. Predicate bits of inactive lanes are ignored, so a predicate that is true only on inactive lanes counts as uniformly false.
- R3: A branch whose predicate is true on every active lane moves pcOut to brTarget. A branch whose predicate is false on every active lane moves pcOut to brFall. In both cases the mask is unchanged and nothing is pushed.
- R4: A branch whose predicate splits the active lanes makes the mask (old mask AND predicate) and pcOut brTarget on the next cycle.
- R5: After a split with brFall different from brRecon, a reach strobe whose PC equals the current reconvergence PC switches the mask to the lanes that were active and had a false predicate, and pcOut to brFall.
- R6: The next matching reach restores the full pre-branch mask with pcOut equal to brRecon, and the enclosing reconvergence PC becomes current again.
- R7: A reach strobe whose PC differs from the current reconvergence PC, or that arrives with an empty stack, changes neither mask nor pcOut.
- R8: A split with brFall equal to brRecon pushes only the rejoin record. A split whose brRecon equals the current reconvergence PC pushes no rejoin record. This lets a loop exit test narrow the mask on each iteration, so that a single reach restores the mask held before the loop.
- R9: Splits nest. Each nested region's inner paths run and rejoin before the enclosing region's second path runs, and each rejoin restores the mask held when that region was entered.
- R10: The stack holds DEPTH (8) records. A split needing more records than are free is dropped and sets overflow. While overflow is set, every branch is ignored, but reach still pops. Only start clears overflow.
- R11: activeCount always equals the number of set bits in activeMask.
- R12: Priority within one cycle is start, then branch, then reach. A reach that coincides with a branch is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load a new warp |
| liveLanes | input | 6 | Number of live lanes for start |
| startPc | input | 16 | Entry PC for start |
| brValid | input | 1 | A branch is presented |
| brPred | input | 32 | Per-lane branch predicate |
| brTarget | input | 16 | Taken target |
| brFall | input | 16 | Fall-through address |
| brRecon | input | 16 | Reconvergence address of the branch |
| reachValid | input | 1 | Fetch reports an arrival PC |
| reachPc | input | 16 | PC the fetch side has arrived at |
| activeMask | output | 32 | Current active lanes |
| activeCount | output | 6 | Number of active lanes |
| pcOut | output | 16 | Next PC to fetch |
| overflow | output | 1 | Sticky stack-overflow flag |

## Verification
The block is driven with several predicate patterns. An all-true and an all-false predicate show that uniform branches only redirect the PC. A threshold split (lanes below 24) shows the ordering of the two passes and the rejoin. A partial warp with predicates on dormant lanes shows that those lanes are masked out. A shrinking loop predicate shows lanes peeling off without stack growth. Two-level nesting and a fourfold nest that fills the stack show rejoin order and overflow. Coinciding strobes show the priority order.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef struct packed {
    logic load;
    logic goTaken;
    logic goFall;
    logic split;
    logic pushJoin;
    logic pushAlt;
    logic pop;
    logic ovfSet;
  } simtCtrl_t;
endpackage

// File: rtl/simt_popcount.sv
module simt_popcount #(
  parameter int LANES = 32,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] bits,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < LANES; i++) count = count + CNT_W'(bits[i]);
  end
endmodule

// File: rtl/simt_ctrl.sv
module simt_ctrl
  import simt_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             brValid,
  input  logic [LANES-1:0] brPred,
  input  logic [PC_W-1:0]  brFall,
  input  logic [PC_W-1:0]  brRecon,
  input  logic             reachValid,
  input  logic [PC_W-1:0]  reachPc,
  input  logic [LANES-1:0] curMask,
  input  logic [PC_W-1:0]  curRpc,
  input  logic [SP_W-1:0]  depth,
  input  logic             overflow,
  output simtCtrl_t        ctrl
);
  logic [LANES-1:0] predAct;
  logic             uniTrue, uniFalse, needJoin, needAlt, room, canPop;
  logic [SP_W:0]    need;

  assign predAct  = brPred & curMask;
  assign uniTrue  = (predAct == curMask);
  assign uniFalse = (predAct == '0);
  assign needJoin = (brRecon != curRpc);
  assign needAlt  = (brFall != brRecon);
  assign need     = {1'b0, depth} + (SP_W+1)'(needJoin) + (SP_W+1)'(needAlt);
  assign room     = (need <= (SP_W+1)'(DEPTH));
  assign canPop   = (depth != '0) && (reachPc == curRpc);

  always_comb begin
    ctrl = '0;
    if (start) begin
      ctrl.load = 1'b1;
    end else if (brValid) begin
      if (!overflow) begin
        if (uniTrue)       ctrl.goTaken = 1'b1;
        else if (uniFalse) ctrl.goFall  = 1'b1;
        else if (room) begin
          ctrl.split    = 1'b1;
          ctrl.pushJoin = needJoin;
          ctrl.pushAlt  = needAlt;
        end else begin
          ctrl.ovfSet = 1'b1;
        end
      end
    end else if (reachValid && canPop) begin
      ctrl.pop = 1'b1;
    end
  end

  // R12: at most one action per cycle
  assert_one_action_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.load, ctrl.goTaken, ctrl.goFall, ctrl.split, ctrl.pop, ctrl.ovfSet}));
endmodule

// File: rtl/simt_datapath.sv
module simt_datapath
  import simt_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  simtCtrl_t        ctrl,
  input  logic [CNT_W-1:0] liveLanes,
  input  logic [PC_W-1:0]  startPc,
  input  logic [LANES-1:0] brPred,
  input  logic [PC_W-1:0]  brTarget,
  input  logic [PC_W-1:0]  brFall,
  input  logic [PC_W-1:0]  brRecon,
  output logic [LANES-1:0] curMask,
  output logic [PC_W-1:0]  curPc,
  output logic [PC_W-1:0]  curRpc,
  output logic [SP_W-1:0]  depth,
  output logic             overflow
);
  logic [LANES-1:0] stkMask [DEPTH];
  logic [PC_W-1:0]  stkPc   [DEPTH];
  logic [PC_W-1:0]  stkRpc  [DEPTH];
  logic [LANES-1:0] liveQ, liveNext;
  logic [SP_W-1:0]  altIdx;
  logic [IDX_W-1:0] topIdx;

  always_comb begin
    for (int i = 0; i < LANES; i++) liveNext[i] = (CNT_W'(i) < liveLanes);
  end

  assign altIdx = depth + SP_W'(ctrl.pushJoin);
  assign topIdx = IDX_W'(depth - SP_W'(1));

  for (genvar e = 0; e < DEPTH; e++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stkMask[e] <= '0;
        stkPc[e]   <= '0;
        stkRpc[e]  <= '0;
      end else if (ctrl.split) begin
        if (ctrl.pushAlt && altIdx == SP_W'(e)) begin
          stkMask[e] <= curMask & ~brPred;
          stkPc[e]   <= brFall;
          stkRpc[e]  <= brRecon;
        end else if (ctrl.pushJoin && depth == SP_W'(e)) begin
          stkMask[e] <= curMask;
          stkPc[e]   <= brRecon;
          stkRpc[e]  <= curRpc;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curMask  <= '0;
      curPc    <= '0;
      curRpc   <= '1;
      depth    <= '0;
      overflow <= 1'b0;
      liveQ    <= '0;
    end else if (ctrl.load) begin
      curMask  <= liveNext;
      liveQ    <= liveNext;
      curPc    <= startPc;
      curRpc   <= '1;
      depth    <= '0;
      overflow <= 1'b0;
    end else if (ctrl.goTaken) begin
      curPc <= brTarget;
    end else if (ctrl.goFall) begin
      curPc <= brFall;
    end else if (ctrl.split) begin
      curMask <= curMask & brPred;
      curPc   <= brTarget;
      curRpc  <= brRecon;
      depth   <= depth + SP_W'(ctrl.pushJoin) + SP_W'(ctrl.pushAlt);
    end else if (ctrl.pop) begin
      curMask <= stkMask[topIdx];
      curPc   <= stkPc[topIdx];
      curRpc  <= stkRpc[topIdx];
      depth   <= depth - SP_W'(1);
    end else if (ctrl.ovfSet) begin
      overflow <= 1'b1;
    end
  end

  // R2: dormant lanes stay off
  assert_dormant_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (curMask & ~liveQ) == '0);
  // R3: uniform branch leaves mask and stack alone
  assert_uniform_nopush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.goTaken || ctrl.goFall) |=> ($stable(depth) && $stable(curMask)));
  // R4: a split only removes lanes and keeps at least one
  assert_split_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.split |=> (((curMask & ~$past(curMask)) == '0) && (curMask != '0)));
  // R10: depth never exceeds capacity
  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= SP_W'(DEPTH));
  // R10: overflow is sticky until load
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ctrl.load) |=> overflow);
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] liveLanes,
  input  logic [PC_W-1:0]  startPc,
  input  logic             brValid,
  input  logic [LANES-1:0] brPred,
  input  logic [PC_W-1:0]  brTarget,
  input  logic [PC_W-1:0]  brFall,
  input  logic [PC_W-1:0]  brRecon,
  input  logic             reachValid,
  input  logic [PC_W-1:0]  reachPc,
  output logic [LANES-1:0] activeMask,
  output logic [CNT_W-1:0] activeCount,
  output logic [PC_W-1:0]  pcOut,
  output logic             overflow
);
  simtCtrl_t       ctrl;
  logic [PC_W-1:0] curRpc;
  logic [SP_W-1:0] depth;

  simt_ctrl #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rst_n(rst_n), .start(start), .brValid(brValid), .brPred(brPred),
    .brFall(brFall), .brRecon(brRecon), .reachValid(reachValid), .reachPc(reachPc),
    .curMask(activeMask), .curRpc(curRpc), .depth(depth), .overflow(overflow),
    .ctrl(ctrl));

  simt_datapath #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) uPath (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .liveLanes(liveLanes), .startPc(startPc),
    .brPred(brPred), .brTarget(brTarget), .brFall(brFall), .brRecon(brRecon),
    .curMask(activeMask), .curPc(pcOut), .curRpc(curRpc), .depth(depth),
    .overflow(overflow));

  simt_popcount #(.LANES(LANES)) uCount (.bits(activeMask), .count(activeCount));

  // R11: lane count tracks the mask
  assert_count_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    activeCount == CNT_W'($countones(activeMask)));
endmodule

// File: tb/simt_reconv_stack_test.sv
module simt_reconv_stack_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  liveLanes = '0;
  logic [15:0] startPc = '0;
  logic        brValid = 1'b0;
  logic [31:0] brPred = '0;
  logic [15:0] brTarget = '0, brFall = '0, brRecon = '0;
  logic        reachValid = 1'b0;
  logic [15:0] reachPc = '0;
  logic [31:0] activeMask;
  logic [5:0]  activeCount;
  logic [15:0] pcOut;
  logic        overflow;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_reconv_stack uut (
    .clk(clk), .rst_n(rst_n), .start(start), .liveLanes(liveLanes), .startPc(startPc),
    .brValid(brValid), .brPred(brPred), .brTarget(brTarget), .brFall(brFall),
    .brRecon(brRecon), .reachValid(reachValid), .reachPc(reachPc),
    .activeMask(activeMask), .activeCount(activeCount), .pcOut(pcOut),
    .overflow(overflow));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chkState(string tag, logic [31:0] m, logic [15:0] pc);
    chk({tag, " mask"}, activeMask, m);
    chk({tag, " pc"}, {16'h0, pcOut}, {16'h0, pc});
    chk({tag, " count R11"}, {26'h0, activeCount}, 32'($countones(m)));
  endtask

  task automatic cyc(logic st, logic [5:0] n, logic [15:0] spc,
                     logic bv, logic [31:0] p, logic [15:0] t, logic [15:0] f,
                     logic [15:0] rc, logic rv, logic [15:0] rp);
    @(negedge clk);
    start = st; liveLanes = n; startPc = spc;
    brValid = bv; brPred = p; brTarget = t; brFall = f; brRecon = rc;
    reachValid = rv; reachPc = rp;
    @(negedge clk);
    start = 0; brValid = 0; reachValid = 0;
  endtask

  task automatic doStart(logic [5:0] n, logic [15:0] pc);
    cyc(1, n, pc, 0, '0, '0, '0, '0, 0, '0);
  endtask
  task automatic doBr(logic [31:0] p, logic [15:0] t, logic [15:0] f, logic [15:0] rc);
    cyc(0, '0, '0, 1, p, t, f, rc, 0, '0);
  endtask
  task automatic doReach(logic [15:0] rp);
    cyc(0, '0, '0, 0, '0, '0, '0, '0, 1, rp);
  endtask

  task automatic testReset();
    chkState("R1 reset", 32'h0, 16'h0);
    chk("R1 reset ovf", {31'h0, overflow}, 32'h0);
    doStart(6'd32, 16'h0010);
    chkState("R1 start full", 32'hffff_ffff, 16'h0010);
  endtask

  task automatic testUniform();
    doStart(6'd32, 16'h0010);
    doBr(32'hffff_ffff, 16'h0020, 16'h0024, 16'h0028);
    chkState("R3 all true", 32'hffff_ffff, 16'h0020);
    doBr(32'h0, 16'h0030, 16'h0034, 16'h0038);
    chkState("R3 all false", 32'hffff_ffff, 16'h0034);
    doReach(16'h0038);
    chkState("R7 no stack", 32'hffff_ffff, 16'h0034);
  endtask

  task automatic testSplit();
    doStart(6'd32, 16'h0000);
    doBr(32'h00ff_ffff, 16'h0030, 16'h0040, 16'h0050);
    chkState("R4 taken pass", 32'h00ff_ffff, 16'h0030);
    doReach(16'h0044);
    chkState("R7 wrong pc", 32'h00ff_ffff, 16'h0030);
    doReach(16'h0050);
    chkState("R5 else pass", 32'hff00_0000, 16'h0040);
    doReach(16'h0050);
    chkState("R6 rejoin", 32'hffff_ffff, 16'h0050);
    doReach(16'h0050);
    chkState("R7 empty stack", 32'hffff_ffff, 16'h0050);
  endtask

  task automatic testPartial();
    doStart(6'd20, 16'h0100);
    chkState("R1 partial start", 32'h000f_ffff, 16'h0100);
    doBr(32'hffff_ffff, 16'h0110, 16'h0114, 16'h0118);
    chkState("R2 dormant ignored true", 32'h000f_ffff, 16'h0110);
    doBr(32'hfff0_0000, 16'h0120, 16'h0124, 16'h0128);
    chkState("R2 dormant-only pred false", 32'h000f_ffff, 16'h0124);
  endtask

  task automatic testLoop();
    doStart(6'd32, 16'h0000);
    doBr(32'hffff_ffff, 16'h0008, 16'h0020, 16'h0020);
    chkState("R8 iter1", 32'hffff_ffff, 16'h0008);
    doBr(32'h0000_ffff, 16'h0008, 16'h0020, 16'h0020);
    chkState("R8 iter2", 32'h0000_ffff, 16'h0008);
    doBr(32'h0000_00ff, 16'h0008, 16'h0020, 16'h0020);
    chkState("R8 iter3", 32'h0000_00ff, 16'h0008);
    doBr(32'h0, 16'h0008, 16'h0020, 16'h0020);
    chkState("R8 exit", 32'h0000_00ff, 16'h0020);
    doReach(16'h0020);
    chkState("R8 restore", 32'hffff_ffff, 16'h0020);
    doReach(16'h0020);
    chkState("R8 single record", 32'hffff_ffff, 16'h0020);
  endtask

  task automatic testNest();
    doStart(6'd32, 16'h0000);
    doBr(32'h0000_ffff, 16'h0100, 16'h0200, 16'h0300);
    doBr(32'h0000_00ff, 16'h0110, 16'h0120, 16'h0130);
    chkState("R9 inner taken", 32'h0000_00ff, 16'h0110);
    doReach(16'h0130);
    chkState("R9 inner else", 32'h0000_ff00, 16'h0120);
    doReach(16'h0130);
    chkState("R9 inner rejoin", 32'h0000_ffff, 16'h0130);
    doReach(16'h0300);
    chkState("R9 outer else", 32'hffff_0000, 16'h0200);
    doReach(16'h0300);
    chkState("R9 outer rejoin", 32'hffff_ffff, 16'h0300);
  endtask

  task automatic testOverflow();
    logic [31:0] preds [4] = '{32'h0000_ffff, 32'h0000_00ff, 32'h0000_000f, 32'h0000_0003};
    doStart(6'd32, 16'h0000);
    for (int k = 0; k < 4; k++)
      doBr(preds[k], 16'h0400 + 16'(k*16), 16'h0404 + 16'(k*16), 16'h0408 + 16'(k*16));
    chkState("R10 full", 32'h0000_0003, 16'h0430);
    chk("R10 not yet ovf", {31'h0, overflow}, 32'h0);
    doBr(32'h0000_0001, 16'h0500, 16'h0504, 16'h0508);
    chkState("R10 dropped", 32'h0000_0003, 16'h0430);
    chk("R10 ovf set", {31'h0, overflow}, 32'h1);
    doBr(32'hffff_ffff, 16'h0600, 16'h0604, 16'h0608);
    chkState("R10 branch blocked", 32'h0000_0003, 16'h0430);
    doReach(16'h0438);
    chkState("R10 pop still works", 32'h0000_000c, 16'h0434);
    chk("R10 ovf held", {31'h0, overflow}, 32'h1);
    doStart(6'd32, 16'h0000);
    chk("R10 start clears", {31'h0, overflow}, 32'h0);
  endtask

  task automatic testPriority();
    doStart(6'd32, 16'h0000);
    doBr(32'h0000_ffff, 16'h0070, 16'h0074, 16'h0078);
    cyc(0, '0, '0, 1, 32'hffff_ffff, 16'h007c, 16'h0080, 16'h0084, 1, 16'h0078);
    chkState("R12 branch over reach", 32'h0000_ffff, 16'h007c);
    doReach(16'h0078);
    chkState("R12 reach later", 32'hffff_0000, 16'h0074);
    cyc(1, 6'd32, 16'h0090, 1, 32'h1, 16'h0099, 16'h009a, 16'h009b, 1, 16'h0078);
    chkState("R12 start wins", 32'hffff_ffff, 16'h0090);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testUniform();
    testSplit();
    testPartial();
    testLoop();
    testNest();
    testOverflow();
    testPriority();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule